// File: doc/BRIEF.md
# Guarded Clock Control Register

This block keeps an 8-bit clock-control word that software cannot change by accident. A store to the word takes effect only if the bus write just before it went to a separate unlock (command) address. A store can replace the whole byte, or it can set, clear or invert a single bit. Each of these forms needs the unlock first. Reads are always allowed. A rejected store raises a one-cycle error pulse.

Three live fields drive the rest of the block:
- **PLL request bit (bit 7).** It drives the PLL enable output. The system clock select switches to the PLL only after the lock indication has passed through a two-flop synchronizer, and only while the clock is ready.
- **Wait-length bit (bit 5).** It picks the short or long count of the wake-up stabilization timer.
- **External-clock bit (bit 4).** It marks the oscillator as bypassed. With it set, the timer uses the short direct-mode counts, and a wake from stop mode skips the wait entirely.

While the timer runs, the clock-ready output stays low.

Top module: `clk_ctl_guard`

## Requirements
- R1: After reset the word reads 0x00, clkReady is 1, pllEnable is 0, sysClkSel is 0 and protErr is 0.
- R2: A read at REG_ADDR returns the word, and bits 6 and 3..0 always read as 0. A read at any other address returns 0.
- R3: When the previous bus access was a write to CMD_ADDR, a write at REG_ADDR with busMode 2'b00 loads busWdata, masked to bits 7, 5 and 4. The new value is readable from the next cycle.
- R4: A write at REG_ADDR that is not preceded by a CMD_ADDR write leaves the word unchanged. protErr is then high for exactly the one cycle after that write.
- R5: Any bus read, or any write to an address other than CMD_ADDR, between the unlock and the store cancels the unlock.
- R6: The bit modes use busWdata[2:0] as the bit index: 2'b01 sets, 2'b10 clears and 2'b11 inverts that bit. Touching bit 6 or bits 3..0 has no effect.
- R7: One unlock permits exactly one store. A second store without a new unlock is rejected.
- R8: A stop-mode wake (wakeReq with wakeSrc=0) while bit 4 is 0 drops clkReady for exactly OSC_SHORT cycles, or OSC_LONG cycles when bit 5 is 1.
- R9: A watch-mode wake (wakeSrc=1) drops clkReady for DIR_SHORT or DIR_LONG cycles (chosen by bit 5) when bit 4 is 1. When bit 4 is 0 it uses the OSC counts instead.
- R10: A stop-mode wake while bit 4 is 1 leaves clkReady at 1.
- R11: pllEnable equals bit 7 of the word from the cycle after the store.
- R12: sysClkSel rises on the third clock edge after pllLock is first sampled high, provided bit 7 is 1 and clkReady is 1. It falls on the edge after bit 7 is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Bus address |
| busWdata | input | 8 | Write data, or the bit index in bit modes |
| busMode | input | 2 | 00 byte, 01 set bit, 10 clear bit, 11 invert bit |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| rdData | output | 8 | Read data |
| protErr | output | 1 | One-cycle pulse on a rejected store |
| wakeReq | input | 1 | Wake-up event pulse |
| wakeSrc | input | 1 | 0 stop-mode wake, 1 watch-mode wake |
| clkReady | output | 1 | Low while the stabilization wait runs |
| pllLock | input | 1 | Asynchronous lock indication |
| pllEnable | output | 1 | PLL enable |
| sysClkSel | output | 1 | 1 selects the PLL as system clock |

## Verification
The hardest condition to reach is an unlock that was cancelled by an unrelated access. From the outside it looks the same as an unlock that never happened, so the bench builds it explicitly: it writes to the unlock address, then inserts a plain read or a stray write, and then attempts the store. The bench confirms the rejection through the error pulse and by reading the word back. A rejected second store after a successful one is exercised the same way. The stabilization counts are shortened through parameters, so every combination of wake source and field setting can be timed to the exact cycle.

// File: rtl/clk_guard_pkg.sv
package clk_guard_pkg;
  typedef enum logic [1:0] {
    WR_BYTE = 2'b00,
    WR_SET  = 2'b01,
    WR_CLR  = 2'b10,
    WR_INV  = 2'b11
  } wrMode_e;

  localparam int PLL_BIT  = 7;
  localparam int LONG_BIT = 5;
  localparam int EXT_BIT  = 4;

  typedef struct packed {
    logic regLoad;
    logic regHit;
  } ctlStrobe_t;
endpackage

// File: rtl/clk_guard_ctl.sv
module clk_guard_ctl
  import clk_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 32'hFFFF_F822,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 32'hFFFF_F800
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output ctlStrobe_t        strobe,
  output logic              protErr
);
  logic armedQ;
  logic errQ;
  logic cmdHit;
  logic regHit;

  assign cmdHit = (busAddr == CMD_ADDR);
  assign regHit = (busAddr == REG_ADDR);

  always_comb begin
    strobe.regHit  = regHit;
    strobe.regLoad = busWr && regHit && armedQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armedQ <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      errQ <= busWr && regHit && !armedQ;
      if (busWr && cmdHit)
        armedQ <= 1'b1;
      else if (busWr || busRd)
        armedQ <= 1'b0;
    end
  end

  assign protErr = errQ;

  // R4: an error pulse is always caused by a store to the word
  assert_err_on_reject_R4: assert property (@(posedge clk) disable iff (!rstN)
    protErr |-> $past(busWr && regHit));

  // R7: one unlock grants one store
  assert_single_use_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.regLoad |=> !strobe.regLoad);
endmodule

// File: rtl/clk_guard_dp.sv
module clk_guard_dp
  import clk_guard_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] LIVE_MASK = 8'hB0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [1:0]        busMode,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] ctlWord
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] regQ;
  logic [DATA_W-1:0] bitSel;
  logic [DATA_W-1:0] nextVal;

  always_comb begin
    bitSel = '0;
    bitSel[busWdata[IDX_W-1:0]] = 1'b1;
    case (wrMode_e'(busMode))
      WR_BYTE: nextVal = busWdata;
      WR_SET:  nextVal = regQ | bitSel;
      WR_CLR:  nextVal = regQ & ~bitSel;
      default: nextVal = regQ ^ bitSel;
    endcase
    nextVal = nextVal & LIVE_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      regQ <= '0;
    else if (strobe.regLoad)
      regQ <= nextVal;
  end

  assign rdData  = strobe.regHit ? regQ : '0;
  assign ctlWord = regQ;

  // R3: the word changes only on a granted store
  assert_change_needs_arm_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regQ != $past(regQ)) |-> $past(strobe.regLoad));
endmodule

// File: rtl/clk_guard_wake.sv
module clk_guard_wake #(
  parameter int OSC_SHORT = 50000,
  parameter int OSC_LONG  = 100000,
  parameter int DIR_SHORT = 5000,
  parameter int DIR_LONG  = 10000
) (
  input  logic clk,
  input  logic rstN,
  input  logic wakeReq,
  input  logic wakeSrc,
  input  logic extClk,
  input  logic longWait,
  output logic clkReady
);
  localparam int MAX_A   = (OSC_SHORT > OSC_LONG) ? OSC_SHORT : OSC_LONG;
  localparam int MAX_B   = (DIR_SHORT > DIR_LONG) ? DIR_SHORT : DIR_LONG;
  localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] cntQ;
  logic             runQ;
  logic             readyQ;
  logic [CNT_W-1:0] lenSel;
  logic             skipWait;

  always_comb begin
    if (extClk)
      lenSel = longWait ? CNT_W'(DIR_LONG) : CNT_W'(DIR_SHORT);
    else
      lenSel = longWait ? CNT_W'(OSC_LONG) : CNT_W'(OSC_SHORT);
  end

  assign skipWait = !wakeSrc && extClk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ   <= '0;
      runQ   <= 1'b0;
      readyQ <= 1'b1;
    end else if (wakeReq && !skipWait) begin
      cntQ   <= lenSel - CNT_W'(1);
      runQ   <= 1'b1;
      readyQ <= 1'b0;
    end else if (wakeReq && runQ) begin
      runQ   <= 1'b0;
      readyQ <= 1'b1;
    end else if (runQ) begin
      if (cntQ == '0) begin
        runQ   <= 1'b0;
        readyQ <= 1'b1;
      end else begin
        cntQ <= cntQ - CNT_W'(1);
      end
    end
  end

  assign clkReady = readyQ;

  // R8: ready only drops because of a wake event
  assert_drop_on_wake_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkReady) |-> $past(wakeReq));

  // R9: ready only returns at the end of a running wait
  assert_rise_after_run_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkReady) |-> $past(runQ));
endmodule

// File: rtl/clk_guard_pll_sync.sv
module clk_guard_pll_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pllOn,
  input  logic pllLock,
  input  logic clkReady,
  output logic sysClkSel
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   selQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      selQ  <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], pllLock};
      selQ  <= pllOn && syncQ[SYNC_STAGES-1] && clkReady;
    end
  end

  assign sysClkSel = selQ;

  // R12: the switch to the PLL needs lock seen three edges earlier and the PLL requested
  assert_sel_after_lock_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysClkSel) |-> ($past(pllLock, 3) && $past(pllOn)));
endmodule

// File: rtl/clk_ctl_guard.sv
module clk_ctl_guard
  import clk_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 32'hFFFF_F822,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 32'hFFFF_F800,
  parameter int OSC_SHORT = 50000,
  parameter int OSC_LONG  = 100000,
  parameter int DIR_SHORT = 5000,
  parameter int DIR_LONG  = 10000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  input  logic [1:0]        busMode,
  input  logic              busWr,
  input  logic              busRd,
  output logic [7:0]        rdData,
  output logic              protErr,
  input  logic              wakeReq,
  input  logic              wakeSrc,
  output logic              clkReady,
  input  logic              pllLock,
  output logic              pllEnable,
  output logic              sysClkSel
);
  ctlStrobe_t strobe;
  logic [7:0] ctlWord;

  clk_guard_ctl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .CMD_ADDR(CMD_ADDR)) ctl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .strobe(strobe), .protErr(protErr)
  );

  clk_guard_dp #(.DATA_W(8), .LIVE_MASK(8'hB0)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata), .busMode(busMode),
    .rdData(rdData), .ctlWord(ctlWord)
  );

  clk_guard_wake #(.OSC_SHORT(OSC_SHORT), .OSC_LONG(OSC_LONG),
                   .DIR_SHORT(DIR_SHORT), .DIR_LONG(DIR_LONG)) wake_i (
    .clk(clk), .rstN(rstN), .wakeReq(wakeReq), .wakeSrc(wakeSrc),
    .extClk(ctlWord[EXT_BIT]), .longWait(ctlWord[LONG_BIT]), .clkReady(clkReady)
  );

  clk_guard_pll_sync #(.SYNC_STAGES(2)) pll_i (
    .clk(clk), .rstN(rstN), .pllOn(ctlWord[PLL_BIT]), .pllLock(pllLock),
    .clkReady(clkReady), .sysClkSel(sysClkSel)
  );

  assign pllEnable = ctlWord[PLL_BIT];
endmodule

// File: tb/clk_ctl_guard_tb_top.sv
module clk_ctl_guard_tb_top;
  localparam logic [31:0] REG_A = 32'hFFFF_F822;
  localparam logic [31:0] CMD_A = 32'hFFFF_F800;
  localparam logic [31:0] OTH_A = 32'hFFFF_F824;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [1:0]  busMode = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  rdData;
  logic        protErr;
  logic        wakeReq = 1'b0;
  logic        wakeSrc = 1'b0;
  logic        clkReady;
  logic        pllLock = 1'b0;
  logic        pllEnable;
  logic        sysClkSel;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic lastErr;

  always #4 clk = ~clk;

  clk_ctl_guard #(.ADDR_W(32), .REG_ADDR(REG_A), .CMD_ADDR(CMD_A),
                  .OSC_SHORT(40), .OSC_LONG(80), .DIR_SHORT(10), .DIR_LONG(20)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata), .busMode(busMode),
    .busWr(busWr), .busRd(busRd), .rdData(rdData), .protErr(protErr),
    .wakeReq(wakeReq), .wakeSrc(wakeSrc), .clkReady(clkReady),
    .pllLock(pllLock), .pllEnable(pllEnable), .sysClkSel(sysClkSel)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [31:0] a, input logic [7:0] d, input logic [1:0] m);
    @(negedge clk);
    busAddr = a; busWdata = d; busMode = m; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; lastErr = protErr; busAddr = '0;
  endtask

  task automatic busRead(input logic [31:0] a, output logic [7:0] v);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    v = rdData; busRd = 1'b0; busAddr = '0;
  endtask

  task automatic guardedWrite(input logic [7:0] d, input logic [1:0] m);
    busWrite(CMD_A, 8'h00, 2'b00);
    busWrite(REG_A, d, m);
  endtask

  task automatic waitLen(input logic src, input int exp, input string req);
    int n = 0;
    @(negedge clk);
    wakeReq = 1'b1; wakeSrc = src;
    @(negedge clk);
    wakeReq = 1'b0;
    while (!clkReady && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check(req, n, exp);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 clkReady", int'(clkReady), 1);
    check("R1 pllEnable", int'(pllEnable), 0);
    check("R1 sysClkSel", int'(sysClkSel), 0);
    check("R1 protErr", int'(protErr), 0);
    busRead(REG_A, v);
    check("R1 word", int'(v), 0);
  endtask

  task automatic t_unarmed();
    logic [7:0] v;
    busWrite(REG_A, 8'hFF, 2'b00);
    check("R4 err pulse", int'(lastErr), 1);
    @(negedge clk);
    check("R4 pulse one cycle", int'(protErr), 0);
    busRead(REG_A, v);
    check("R4 word unchanged", int'(v), 0);
  endtask

  task automatic t_byte();
    logic [7:0] v;
    guardedWrite(8'hFF, 2'b00);
    check("R3 no error", int'(lastErr), 0);
    busRead(REG_A, v);
    check("R3 R2 masked load", int'(v), 8'hB0);
    busRead(OTH_A, v);
    check("R2 other address", int'(v), 0);
  endtask

  task automatic t_reuse();
    logic [7:0] v;
    guardedWrite(8'h10, 2'b00);
    busWrite(REG_A, 8'h00, 2'b00);
    check("R7 second store rejected", int'(lastErr), 1);
    busRead(REG_A, v);
    check("R7 word kept", int'(v), 8'h10);
  endtask

  task automatic t_intervene();
    logic [7:0] v;
    busWrite(CMD_A, 8'h00, 2'b00);
    busRead(OTH_A, v);
    busWrite(REG_A, 8'h00, 2'b00);
    check("R5 read cancels", int'(lastErr), 1);
    busWrite(CMD_A, 8'h00, 2'b00);
    busWrite(OTH_A, 8'h55, 2'b00);
    busWrite(REG_A, 8'h00, 2'b00);
    check("R5 stray write cancels", int'(lastErr), 1);
    busRead(REG_A, v);
    check("R5 word kept", int'(v), 8'h10);
    guardedWrite(8'h00, 2'b00);
    busRead(REG_A, v);
    check("R3 cleared", int'(v), 0);
  endtask

  task automatic t_bits();
    logic [7:0] v;
    guardedWrite(8'h04, 2'b01);
    busRead(REG_A, v);
    check("R6 set bit4", int'(v), 8'h10);
    guardedWrite(8'h07, 2'b11);
    busRead(REG_A, v);
    check("R6 invert bit7", int'(v), 8'h90);
    check("R11 pllEnable on", int'(pllEnable), 1);
    guardedWrite(8'h04, 2'b10);
    busRead(REG_A, v);
    check("R6 clear bit4", int'(v), 8'h80);
    guardedWrite(8'h06, 2'b01);
    busRead(REG_A, v);
    check("R6 reserved bit6", int'(v), 8'h80);
    guardedWrite(8'h01, 2'b11);
    busRead(REG_A, v);
    check("R6 reserved bit1", int'(v), 8'h80);
    guardedWrite(8'h00, 2'b00);
    check("R11 pllEnable off", int'(pllEnable), 0);
  endtask

  task automatic t_wake();
    guardedWrite(8'h00, 2'b00);
    waitLen(1'b0, 40, "R8 stop short");
    guardedWrite(8'h20, 2'b00);
    waitLen(1'b0, 80, "R8 stop long");
    guardedWrite(8'h10, 2'b00);
    waitLen(1'b1, 10, "R9 watch direct short");
    guardedWrite(8'h30, 2'b00);
    waitLen(1'b1, 20, "R9 watch direct long");
    waitLen(1'b0, 0, "R10 stop skipped");
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!clkReady) begin
        check("R10 ready held", 0, 1);
        break;
      end
    end
    guardedWrite(8'h00, 2'b00);
    waitLen(1'b1, 40, "R9 watch osc short");
  endtask

  task automatic t_pll();
    guardedWrite(8'h80, 2'b00);
    check("R11 pllEnable", int'(pllEnable), 1);
    @(negedge clk);
    pllLock = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R12 sel waits", int'(sysClkSel), 0);
    @(negedge clk);
    check("R12 sel after sync", int'(sysClkSel), 1);
    guardedWrite(8'h00, 2'b00);
    check("R11 pllEnable cleared", int'(pllEnable), 0);
    @(negedge clk);
    check("R12 sel drops", int'(sysClkSel), 0);
    pllLock = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_unarmed();
    t_byte();
    t_reuse();
    t_intervene();
    t_bits();
    t_wake();
    t_pll();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule